// File: doc/BRIEF.md
# Peripheral Security Access Gate

The gate sits between one bus master and up to sixteen peripheral ports. Every request names a target port and carries a secure bit and a user (unprivileged) bit. Before anything reaches a peripheral, the gate checks these bits against two configuration bits for that port. One bit says whether the port belongs to the non-secure world. The other says whether unprivileged code may reach it. A request that passes is forwarded to the chosen port with its address, data, size and attributes unchanged, and that port's response comes back to the master unchanged. A request that fails never reaches any peripheral. The gate answers it locally and records the violation in a sticky status bit, which can raise an interrupt.

A build-time mask can turn off the world check for chosen ports, while the privilege check still applies to them. A second build-time bitmap lists the ports that are actually connected. A global input selects how refused requests are answered: with an error, or silently (reads give zero, writes are dropped).

The controller is a four-state machine. In `ST_IDLE` it is ready, and it leaves on acceptance: by the `allow` transition to `ST_FWD`, or by the `refuse` transition to `ST_DENY`. `ST_FWD` drives one downstream valid and takes the `granted` transition to `ST_RESP` on that port's ready. `ST_RESP` relays the port's response and takes the `returned` transition back to `ST_IDLE` when the port's response valid is seen. `ST_DENY` issues the local answer and takes the `answered` transition back to `ST_IDLE` after one cycle.

Top module: `periph_sec_gate`

## Requirements
- R1: An allowed request accepted at a clock edge drives exactly one downstream valid, bit `port`, from the next cycle. It carries the request's address, write flag, write data, size code (0=1, 1=2, 2=4, 3=8 bytes) and secure and user bits unchanged, and it holds them until that port's ready is sampled high.
- R2: After the downstream handshake, the upstream response valid, read data and error equal the selected port's response valid, data and error, cycle for cycle. `up_ready` stays low from acceptance until that response has been seen.
- R3: A request is refused when its secure bit equals the port's non-secure configuration bit (1 = non-secure port).
- R4: For ports whose bit is set in parameter `SEC_BYPASS`, the world check is skipped.
- R5: A user request is refused when the port's privilege-permit bit is 0, including on ports in `SEC_BYPASS`.
- R6: A request to a port whose bit is clear in parameter `PORT_PRESENT` is refused.
- R7: With `cfg_err_resp` = 1, a refused request is answered with `up_err` = 1 and zero read data.
- R8: With `cfg_err_resp` = 0, a refused read returns zero data with `up_err` = 0, and a refused write is dropped with `up_err` = 0.
- R9: A refused request is answered in the cycle after acceptance (`up_rvalid` = 1 for one cycle), and no downstream valid rises for it.
- R10: Each refused request sets a sticky status bit. `irq` = status AND `irq_en`.
- R11: While `irq_clr` is high, the status is cleared at each clock edge and refusals do not set it. A refusal and a high `irq_clr` at the same edge leave it clear.
- R12: Reset clears the status, the state machine and the registered configuration (all ports secure, no user access, silent answers). Configuration inputs take effect one clock after they are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Request valid |
| up_ready | output | 1 | Gate can accept a request |
| up_port | input | PW | Target port index |
| up_addr | input | AW | Address |
| up_write | input | 1 | 1 = write |
| up_wdata | input | DW | Write data |
| up_size | input | 2 | Size code |
| up_secure | input | 1 | Secure attribute |
| up_user | input | 1 | Unprivileged attribute |
| up_rvalid | output | 1 | Response valid |
| up_rdata | output | DW | Response data |
| up_err | output | 1 | Error response |
| cfg_nonsec | input | NPORTS | Per-port non-secure bit |
| cfg_user_ok | input | NPORTS | Per-port privilege permit |
| cfg_err_resp | input | 1 | 1 = refuse with error |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Status clear, level |
| irq | output | 1 | Violation interrupt |
| dn_valid | output | NPORTS | Per-port request valid |
| dn_ready | input | NPORTS | Per-port request ready |
| dn_addr | output | AW | Forwarded address |
| dn_write | output | 1 | Forwarded write flag |
| dn_wdata | output | DW | Forwarded write data |
| dn_size | output | 2 | Forwarded size code |
| dn_secure | output | 1 | Forwarded secure bit |
| dn_user | output | 1 | Forwarded user bit |
| dn_rvalid | input | NPORTS | Per-port response valid |
| dn_rdata | input | NPORTS*DW | Per-port response data, port n at bits n*DW |
| dn_err | input | NPORTS | Per-port error |

## Verification
The hardest case to reach from the ports is a refusal that lands on the same edge as a high `irq_clr`. The stimulus gets there by holding clear across whole refused transactions, and it then checks that `irq` stays low once the enable is raised. The bench is built with a nonzero bypass mask and one absent port. With that build, random attribute and configuration mixes reach the bypassed-but-unprivileged refusal and the absent-port refusal. A reset case keeps the configuration inputs at all ones while a request arrives on the first edge after reset. The request is allowed, which shows that the registered configuration was still zero.

// File: rtl/psg_pkg.sv
package psg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_RESP = 2'd2,
        ST_DENY = 2'd3
    } psg_state_e;

    localparam int SIZE_W = 2;
endpackage

// File: rtl/psg_access_check.sv
module psg_access_check #(
    parameter int          NPORTS       = 16,
    parameter logic [15:0] SEC_BYPASS   = 16'h0000,
    parameter logic [15:0] PORT_PRESENT = 16'hFFFF,
    localparam int         PW           = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [PW-1:0]     port,
    input  logic              secure,
    input  logic              user,
    input  logic [NPORTS-1:0] nonsec_q,
    input  logic [NPORTS-1:0] user_ok_q,
    output logic              deny
);
    logic [NPORTS-1:0] refuse_vec;

    // one decision slice per port, the request's index then picks one
    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        logic world_bad;
        logic priv_bad;
        if (SEC_BYPASS[g]) begin : g_byp
            assign world_bad = 1'b0;
        end else begin : g_chk
            assign world_bad = (secure == nonsec_q[g]);
        end
        assign priv_bad      = user && !user_ok_q[g];
        assign refuse_vec[g] = !PORT_PRESENT[g] || world_bad || priv_bad;
    end

    always_comb begin
        if (int'(port) < NPORTS) deny = refuse_vec[port];
        else                     deny = 1'b1;
    end
endmodule

// File: rtl/psg_irq.sv
module psg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic deny_evt,
    input  logic irq_clr,
    input  logic irq_en,
    output logic irq
);
    logic status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        status_q <= 1'b0;
        else if (irq_clr)  status_q <= 1'b0;
        else if (deny_evt) status_q <= 1'b1;
    end

    assign irq = status_q && irq_en;

    // R11
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !status_q);
    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !irq_clr) |=> status_q);
    // R10
    set_on_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deny_evt && !irq_clr) |=> status_q);
endmodule

// File: rtl/psg_ctrl.sv
module psg_ctrl
    import psg_pkg::*;
#(
    parameter int  NPORTS = 16,
    parameter int  AW     = 32,
    parameter int  DW     = 64,
    localparam int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_valid,
    output logic               up_ready,
    input  logic [PW-1:0]      up_port,
    input  logic [AW-1:0]      up_addr,
    input  logic               up_write,
    input  logic [DW-1:0]      up_wdata,
    input  logic [SIZE_W-1:0]  up_size,
    input  logic               up_secure,
    input  logic               up_user,
    input  logic               deny,
    input  logic               err_mode,
    output logic               up_rvalid,
    output logic [DW-1:0]      up_rdata,
    output logic               up_err,
    output logic               deny_evt,
    output logic [NPORTS-1:0]  dn_valid,
    input  logic [NPORTS-1:0]  dn_ready,
    output logic [AW-1:0]      dn_addr,
    output logic               dn_write,
    output logic [DW-1:0]      dn_wdata,
    output logic [SIZE_W-1:0]  dn_size,
    output logic               dn_secure,
    output logic               dn_user,
    input  logic [NPORTS-1:0]  dn_rvalid,
    input  logic [NPORTS*DW-1:0] dn_rdata,
    input  logic [NPORTS-1:0]  dn_err
);
    psg_state_e state_q, state_d;
    logic [PW-1:0] port_q;
    logic          accept;
    logic          sel_ready, sel_rvalid, sel_err;
    logic [DW-1:0] sel_rdata;

    assign accept   = up_valid && (state_q == ST_IDLE);
    assign deny_evt = accept && deny;

    always_comb begin
        sel_ready  = 1'b0;
        sel_rvalid = 1'b0;
        sel_err    = 1'b0;
        sel_rdata  = '0;
        if (int'(port_q) < NPORTS) begin
            sel_ready  = dn_ready[port_q];
            sel_rvalid = dn_rvalid[port_q];
            sel_err    = dn_err[port_q];
            sel_rdata  = dn_rdata[int'(port_q)*DW +: DW];
        end
    end

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            port_q    <= '0;
            dn_addr   <= '0;
            dn_write  <= 1'b0;
            dn_wdata  <= '0;
            dn_size   <= '0;
            dn_secure <= 1'b0;
            dn_user   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                port_q    <= up_port;
                dn_addr   <= up_addr;
                dn_write  <= up_write;
                dn_wdata  <= up_wdata;
                dn_size   <= up_size;
                dn_secure <= up_secure;
                dn_user   <= up_user;
            end
        end
    end

    // transitions: allow, refuse, granted, returned, answered
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = deny ? ST_DENY : ST_FWD;
            ST_FWD:  if (sel_ready) state_d = ST_RESP;
            ST_RESP: if (sel_rvalid) state_d = ST_IDLE;
            ST_DENY: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    for (genvar g = 0; g < NPORTS; g++) begin : g_dnv
        assign dn_valid[g] = (state_q == ST_FWD) && (int'(port_q) == g);
    end

    always_comb begin
        up_ready  = 1'b0;
        up_rvalid = 1'b0;
        up_rdata  = '0;
        up_err    = 1'b0;
        unique case (state_q)
            ST_IDLE: up_ready = 1'b1;
            ST_FWD:  ;
            ST_RESP: begin
                up_rvalid = sel_rvalid;
                up_rdata  = sel_rdata;
                up_err    = sel_err;
            end
            ST_DENY: begin
                up_rvalid = 1'b1;
                up_err    = err_mode;
            end
            default: ;
        endcase
    end

    // R9
    deny_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && deny) |=> (up_rvalid && (dn_valid == '0) && !up_ready));
    // R8
    deny_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && deny) |=> (up_rdata == '0));
    // R7
    deny_err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && deny) |=> (up_err == err_mode));
    // R1
    fwd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !deny) |=> ($countones(dn_valid) == 1));
    // R1
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_valid));
    // R1
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dn_valid != '0) && !sel_ready) |=> ($stable(dn_valid) && $stable(dn_addr)));
endmodule

// File: rtl/periph_sec_gate.sv
module periph_sec_gate
    import psg_pkg::*;
#(
    parameter int          NPORTS       = 16,
    parameter int          AW           = 32,
    parameter int          DW           = 64,
    parameter logic [15:0] SEC_BYPASS   = 16'h0000,
    parameter logic [15:0] PORT_PRESENT = 16'hFFFF,
    localparam int         PW           = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 up_valid,
    output logic                 up_ready,
    input  logic [PW-1:0]        up_port,
    input  logic [AW-1:0]        up_addr,
    input  logic                 up_write,
    input  logic [DW-1:0]        up_wdata,
    input  logic [1:0]           up_size,
    input  logic                 up_secure,
    input  logic                 up_user,
    output logic                 up_rvalid,
    output logic [DW-1:0]        up_rdata,
    output logic                 up_err,
    input  logic [NPORTS-1:0]    cfg_nonsec,
    input  logic [NPORTS-1:0]    cfg_user_ok,
    input  logic                 cfg_err_resp,
    input  logic                 irq_en,
    input  logic                 irq_clr,
    output logic                 irq,
    output logic [NPORTS-1:0]    dn_valid,
    input  logic [NPORTS-1:0]    dn_ready,
    output logic [AW-1:0]        dn_addr,
    output logic                 dn_write,
    output logic [DW-1:0]        dn_wdata,
    output logic [1:0]           dn_size,
    output logic                 dn_secure,
    output logic                 dn_user,
    input  logic [NPORTS-1:0]    dn_rvalid,
    input  logic [NPORTS*DW-1:0] dn_rdata,
    input  logic [NPORTS-1:0]    dn_err
);
    logic [NPORTS-1:0] nonsec_q, user_ok_q;
    logic              err_mode_q;
    logic              deny, deny_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nonsec_q   <= '0;
            user_ok_q  <= '0;
            err_mode_q <= 1'b0;
        end else begin
            nonsec_q   <= cfg_nonsec;
            user_ok_q  <= cfg_user_ok;
            err_mode_q <= cfg_err_resp;
        end
    end

    psg_access_check #(
        .NPORTS(NPORTS), .SEC_BYPASS(SEC_BYPASS), .PORT_PRESENT(PORT_PRESENT)
    ) u_check (
        .port(up_port), .secure(up_secure), .user(up_user),
        .nonsec_q(nonsec_q), .user_ok_q(user_ok_q), .deny(deny)
    );

    psg_ctrl #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_port(up_port),
        .up_addr(up_addr), .up_write(up_write), .up_wdata(up_wdata),
        .up_size(up_size), .up_secure(up_secure), .up_user(up_user),
        .deny(deny), .err_mode(err_mode_q),
        .up_rvalid(up_rvalid), .up_rdata(up_rdata), .up_err(up_err),
        .deny_evt(deny_evt),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
        .dn_write(dn_write), .dn_wdata(dn_wdata), .dn_size(dn_size),
        .dn_secure(dn_secure), .dn_user(dn_user),
        .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata), .dn_err(dn_err)
    );

    psg_irq u_irq (
        .clk(clk), .rst_n(rst_n), .deny_evt(deny_evt),
        .irq_clr(irq_clr), .irq_en(irq_en), .irq(irq)
    );

    // R12
    cfg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (nonsec_q == $past(cfg_nonsec)));
endmodule

// File: tb/tb_periph_sec_gate.sv
module tb_periph_sec_gate;
    localparam int          CLK_PERIOD = 10;
    localparam int          NP  = 16;
    localparam int          AW  = 32;
    localparam int          DW  = 64;
    localparam logic [15:0] BYP = 16'h00F0;
    localparam logic [15:0] PRS = 16'h7FFF;

    logic clk = 0, rst_n = 0;
    logic up_valid = 0, up_ready;
    logic [3:0] up_port = 0;
    logic [AW-1:0] up_addr = 0;
    logic up_write = 0;
    logic [DW-1:0] up_wdata = 0;
    logic [1:0] up_size = 0;
    logic up_secure = 0, up_user = 0;
    logic up_rvalid, up_err;
    logic [DW-1:0] up_rdata;
    logic [NP-1:0] cfg_nonsec = 0, cfg_user_ok = 0;
    logic cfg_err_resp = 0, irq_en = 0, irq_clr = 0, irq;
    logic [NP-1:0] dn_valid, dn_ready = 0, dn_rvalid = 0, dn_err = 0;
    logic [AW-1:0] dn_addr;
    logic dn_write, dn_secure, dn_user;
    logic [DW-1:0] dn_wdata;
    logic [1:0] dn_size;
    logic [NP*DW-1:0] dn_rdata = 0;

    int checks = 0, errors = 0;
    logic [NP-1:0] m_ns = 0, m_ap = 0;
    logic m_err = 0, m_status = 0;

    periph_sec_gate #(.NPORTS(NP), .AW(AW), .DW(DW), .SEC_BYPASS(BYP), .PORT_PRESENT(PRS)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_deny(input int p, input bit sec, input bit usr);
        return !PRS[p] || (!BYP[p] && (sec == m_ns[p])) || (usr && !m_ap[p]);
    endfunction

    function automatic string deny_tag(input int p, input bit usr);
        if (!PRS[p]) return "R6";
        if (usr && !m_ap[p]) return "R5";
        if (BYP[p]) return "R4";
        return "R3";
    endfunction

    task automatic set_cfg(input logic [NP-1:0] ns, input logic [NP-1:0] ap, input bit em);
        @(negedge clk);
        cfg_nonsec = ns; cfg_user_ok = ap; cfg_err_resp = em;
        m_ns = ns; m_ap = ap; m_err = em;
    endtask

    task automatic do_req(input bit no_wait, input int p, input logic [AW-1:0] a,
                          input bit wr, input logic [DW-1:0] wd, input logic [1:0] sz,
                          input bit sec, input bit usr, input int stall);
        bit d;
        logic [DW-1:0] rd;
        bit re;
        string t;
        d = exp_deny(p, sec, usr);
        if (!no_wait) @(negedge clk);
        up_valid = 1; up_port = p[3:0]; up_addr = a; up_write = wr;
        up_wdata = wd; up_size = sz; up_secure = sec; up_user = usr;
        @(negedge clk);
        up_valid = 0;
        if (irq_clr) m_status = 0;
        else if (d) m_status = 1;
        if (d) begin
            t = deny_tag(p, usr);
            chk(dn_valid == 0, t, "refused yet forwarded (R9)", 64'(dn_valid), 0);
            chk(up_rvalid == 1, "R9", "local answer valid", 64'(up_rvalid), 1);
            chk(up_rdata == 0, m_err ? "R7" : "R8", "refused data", up_rdata, 0);
            chk(up_err == m_err, m_err ? "R7" : "R8", "refused err", 64'(up_err), 64'(m_err));
        end else begin
            chk(dn_valid == (NP'(1) << p), "R1", "dn_valid", 64'(dn_valid), 64'(NP'(1) << p));
            chk(dn_addr == a && dn_write == wr && dn_wdata == wd && dn_size == sz &&
                dn_secure == sec && dn_user == usr, "R1", "forwarded fields",
                {dn_addr, 27'd0, dn_size, dn_write, dn_secure, dn_user}, {a, 27'd0, sz, wr, sec, usr});
            for (int k = 0; k < stall; k++) begin
                @(negedge clk);
                chk(dn_valid == (NP'(1) << p), "R1", "held while stalled", 64'(dn_valid), 64'(NP'(1) << p));
            end
            dn_ready[p] = 1;
            @(negedge clk);
            dn_ready = 0;
            chk(dn_valid == 0 && up_rvalid == 0 && up_ready == 0, "R2", "waiting for port",
                {61'd0, dn_valid != 0, up_rvalid, up_ready}, 0);
            rd = {a, ~a} ^ DW'(p);
            re = a[0];
            dn_rdata = {NP{64'hDEAD_BEEF_0BAD_F00D}};
            dn_rdata[p*DW +: DW] = rd;
            dn_err[p] = re; dn_rvalid[p] = 1;
            #1;
            chk(up_rvalid == 1 && up_rdata == rd, "R2", "response data", up_rdata, rd);
            chk(up_err == re, "R2", "response err", 64'(up_err), 64'(re));
            @(negedge clk);
            dn_rvalid = 0; dn_err = 0;
            chk(up_ready == 1, "R2", "ready after return", 64'(up_ready), 1);
        end
        chk(irq == (m_status && irq_en), d ? "R10" : "R1", "irq", 64'(irq), 64'(m_status && irq_en));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        cfg_nonsec = '1; cfg_user_ok = '1; cfg_err_resp = 1;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(up_rvalid == 0 && dn_valid == 0 && irq == 0, "R12", "outputs in reset",
            {up_rvalid, irq, dn_valid}, 0);
        // R12: registered config still zero on first edge, so a secure access to port 0 passes
        rst_n = 1;
        m_ns = 0; m_ap = 0; m_err = 0;
        do_req(1, 0, 32'h100, 0, 64'h0, 2'd2, 1, 0, 0);
        m_ns = '1; m_ap = '1; m_err = 1;
        // R12: now config ones are in effect, same request refused with error
        do_req(0, 0, 32'h104, 0, 64'h0, 2'd2, 1, 0, 0);

        set_cfg(16'h00AA, 16'h0F0F, 0);
        irq_en = 1;
        @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0; m_status = 0;
        do_req(0, 0, 32'h1000, 1, 64'h1122_3344_5566_7788, 2'd3, 1, 0, 2); // R1 secure to secure
        do_req(0, 1, 32'h1010, 0, 64'h0, 2'd0, 1, 0, 0);  // R3 secure to non-secure
        do_req(0, 0, 32'h1020, 0, 64'h0, 2'd1, 0, 0, 0);  // R3 non-secure to secure
        do_req(0, 4, 32'h1030, 0, 64'h0, 2'd2, 0, 0, 1);  // R4 bypass, ns bit 0
        do_req(0, 5, 32'h1040, 1, 64'hAB, 2'd0, 1, 0, 0); // R4 bypass, ns bit 1
        do_req(0, 6, 32'h1050, 0, 64'h0, 2'd2, 0, 1, 0);  // R5 bypass but user refused
        do_req(0, 0, 32'h1061, 0, 64'h0, 2'd2, 1, 1, 0);  // R5 user permitted
        do_req(0, 15, 32'h1070, 0, 64'h0, 2'd2, 1, 0, 0); // R6 absent port
        do_req(0, 2, 32'h1080, 1, 64'h55, 2'd3, 0, 0, 0); // R8 write dropped
        set_cfg(16'h00AA, 16'h0F0F, 1);
        do_req(0, 3, 32'h1090, 0, 64'h0, 2'd2, 1, 0, 0);  // R7 error answer
        // R10: enable gates the output but not the status
        @(negedge clk); irq_en = 0;
        #1 chk(irq == 0, "R10", "irq masked", 64'(irq), 0);
        @(negedge clk); irq_en = 1;
        #1 chk(irq == 1, "R10", "status sticky", 64'(irq), 1);
        // R11: clear held across a refusal leaves status clear
        @(negedge clk); irq_clr = 1;
        do_req(0, 1, 32'h10A0, 0, 64'h0, 2'd0, 1, 0, 0);
        do_req(0, 15, 32'h10B0, 1, 64'h0, 2'd0, 0, 0, 0);
        @(negedge clk); irq_clr = 0;
        #1 chk(irq == 0, "R11", "refusal under clear", 64'(irq), 0);

        for (int i = 0; i < 400; i++) begin
            if (i % 25 == 0) set_cfg(NP'($urandom), NP'($urandom), 1'($urandom));
            if (i % 37 == 0) begin
                @(negedge clk); irq_en = 1'($urandom);
            end
            if (i % 53 == 0) begin
                @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0; m_status = 0;
            end
            do_req(0, int'($urandom_range(0, 15)), $urandom, 1'($urandom),
                   {$urandom, $urandom}, 2'($urandom), 1'($urandom), 1'($urandom),
                   int'($urandom_range(0, 2)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule